// File: doc/BRIEF.md
# Two-Page Code Block Output Buffer

This block sits at the tail of a soft-decision block decoder and holds finished code blocks until a downstream consumer collects them. A writer pushes 16-bit words, each packing four 4-bit soft samples, and flags the first word of every block. Two size selectors, sampled with that first word, fix how many words the block holds. Storage is split into two pages, and each page holds exactly one complete block. The writer can therefore fill one page while the consumer drains the other.

The consumer watches a ready flag and issues one-cycle read strobes. Each accepted strobe returns one word a fixed four cycles later. The returned word carries a valid flag and a start-of-block marker. Misuse of the flow control raises sticky overflow or underflow faults. A fault discards everything held and everything in progress. The faults clear once a fresh block has been written and fully read out.

Top module: `blkbuf_two_page`

## Requirements
- R1: A word is returned exactly as written, so its four samples keep their order: bits [3:0] hold the earliest sample and bits [15:12] the latest.
- R2: Two complete blocks can be held at the same time without any fault.
- R3: `rdy` is high whenever at least one complete block still has unread words, and low otherwise.
- R4: Words of a block come out in the order they were written, and blocks come out in the order they were completed. `rd_sob` is high only with the first word of a block.
- R5: `rd_valid` is high exactly four cycles after each accepted read strobe (`rd_req` high while `rdy` is high), and at no other time.
- R6: A read strobe while `rdy` is low sets `unf_flt` and returns no word.
- R7: A start word written while both pages hold unread blocks sets `ovf_flt`, and the word is discarded. A start word in the same cycle as the read of the final word of the older block is accepted without a fault.
- R8: Either fault empties both pages and drops any partly written block, so `rdy` is low on the next cycle. Both fault flags stay high until the final word of a block written after the fault has been read; then both clear together.
- R9: A block holds 16 << (`sz_x` + `sz_y`) words. Each selector value s stands for a code length of 8 << s samples along that axis. The selectors are sampled only with the start word, and later changes within the block have no effect.
- R10: A start word while a block is still being written abandons that block and starts a new one on the same page.
- R11: After reset, `rdy`, `rd_valid`, `ovf_flt` and `unf_flt` are low and no block is held.
- R12: Words written with `wr_sob` low while no block is being written are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write word strobe |
| wr_sob | input | 1 | Marks the first word of a block |
| wr_data | input | 16 | Four packed 4-bit samples, earliest in [3:0] |
| sz_x | input | 2 | Row code length selector (8 << value samples) |
| sz_y | input | 2 | Column code length selector (8 << value samples) |
| rd_req | input | 1 | One-cycle read strobe, one per word |
| rdy | output | 1 | A complete block has unread words |
| rd_valid | output | 1 | `rd_data` holds a returned word |
| rd_sob | output | 1 | Returned word is the first of its block |
| rd_data | output | 16 | Returned word |
| ovf_flt | output | 1 | Sticky overflow fault |
| unf_flt | output | 1 | Sticky underflow fault |

## Verification
The assertions assume a writer that keeps `wr_sob` to one word per block and a consumer that issues single-cycle strobes. They also assume the four-cycle return path is never stalled, because no backpressure exists on the output. The stimulus mostly gates `rd_req` with `rdy` and writes each block in full. It steps outside these limits only on purpose, to provoke the overflow, underflow, restarted-block and stray-word cases, and it then checks the recovery that follows.

// File: rtl/blkbuf_pkg.sv
package blkbuf_pkg;
  localparam int SMP_W  = 4;
  localparam int LANES  = 4;
  localparam int WORD_W = SMP_W * LANES;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  vld;
    logic  sob;
    word_t data;
  } beat_t;
endpackage

// File: rtl/blkbuf_store.sv
module blkbuf_store #(
  parameter int W  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW:0]   waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW:0]   raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 2 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/blkbuf_wr_ctrl.sv
module blkbuf_wr_ctrl #(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 3,
  parameter int LANES    = 4,
  parameter int AW       = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  wr_en,
  input  logic                  wr_sob,
  input  logic [SEL_W-1:0]      sz_x,
  input  logic [SEL_W-1:0]      sz_y,
  input  logic [1:0]            page_full,
  input  logic                  rd_last,
  input  logic                  rd_page,
  output logic                  mem_we,
  output logic [AW:0]           mem_waddr,
  output logic                  ovf_evt,
  output logic                  blk_done,
  output logic                  wr_page,
  output logic [1:0][AW-1:0]    plen_m1
);
  localparam int LW_BASE = 2 * MIN_LOG2 - $clog2(LANES);

  logic                 act_q, act_d;
  logic                 wp_q, wp_d;
  logic [AW-1:0]        idx_q, idx_d;
  logic [AW-1:0]        len_q, len_d;
  logic [1:0][AW-1:0]   plen_q, plen_d;

  int            shamt;
  logic [AW:0]   span;
  logic [AW-1:0] len_new, cur_len, wr_idx;
  logic          start, page_busy;

  assign shamt     = LW_BASE + int'(sz_x) + int'(sz_y);
  assign span      = (AW+1)'(1) << shamt;
  assign len_new   = AW'(span - (AW+1)'(1));
  assign start     = wr_en && wr_sob;
  assign page_busy = page_full[wp_q] && !(rd_last && (rd_page == wp_q));
  assign ovf_evt   = start && page_busy;
  assign mem_we    = !flush && ((start && !page_busy) || (wr_en && !wr_sob && act_q));
  assign wr_idx    = start ? '0 : idx_q;
  assign cur_len   = start ? len_new : len_q;
  assign blk_done  = mem_we && (wr_idx == cur_len);
  assign mem_waddr = {wp_q, wr_idx};
  assign wr_page   = wp_q;
  assign plen_m1   = plen_q;

  always_comb begin
    act_d  = act_q;
    wp_d   = wp_q;
    idx_d  = idx_q;
    len_d  = len_q;
    plen_d = plen_q;
    if (flush) begin
      act_d = 1'b0;
      wp_d  = 1'b0;
      idx_d = '0;
    end else if (mem_we) begin
      if (blk_done) begin
        act_d        = 1'b0;
        wp_d         = ~wp_q;
        plen_d[wp_q] = cur_len;
      end else begin
        act_d = 1'b1;
        idx_d = wr_idx + 1'b1;
        len_d = cur_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wp_q   <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      plen_q <= '0;
    end else begin
      act_q  <= act_d;
      wp_q   <= wp_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      plen_q <= plen_d;
    end
  end

  // R7: a refused start word leaves no block open
  p_drop_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !act_q);
endmodule

// File: rtl/blkbuf_rd_ctrl.sv
module blkbuf_rd_ctrl #(
  parameter int AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                rd_req,
  input  logic [1:0]          page_full,
  input  logic [1:0][AW-1:0]  plen_m1,
  output logic                rdy,
  output logic                acc,
  output logic                unf_evt,
  output logic                rd_last,
  output logic                rd_page,
  output logic                first,
  output logic [AW:0]         mem_raddr
);
  logic          rp_q, rp_d;
  logic [AW-1:0] ridx_q, ridx_d;

  assign rdy       = page_full[rp_q];
  assign acc       = rd_req && rdy;
  assign unf_evt   = rd_req && !rdy;
  assign rd_last   = acc && (ridx_q == plen_m1[rp_q]);
  assign first     = (ridx_q == '0);
  assign rd_page   = rp_q;
  assign mem_raddr = {rp_q, ridx_q};

  always_comb begin
    rp_d   = rp_q;
    ridx_d = ridx_q;
    if (flush) begin
      rp_d   = 1'b0;
      ridx_d = '0;
    end else if (acc) begin
      if (rd_last) begin
        rp_d   = ~rp_q;
        ridx_d = '0;
      end else begin
        ridx_d = ridx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q   <= 1'b0;
      ridx_q <= '0;
    end else begin
      rp_q   <= rp_d;
      ridx_q <= ridx_d;
    end
  end
endmodule

// File: rtl/blkbuf_rd_pipe.sv
module blkbuf_rd_pipe
  import blkbuf_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  acc,
  input  logic  first,
  input  word_t mem_q,
  output beat_t tail
);
  logic  v1_q, s1_q;
  beat_t head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      v1_q <= acc;
      s1_q <= acc && first;
    end
  end

  assign head = '{vld: v1_q, sob: s1_q, data: mem_q};

  if (LAT == 1) begin : g_direct
    assign tail = head;
  end else begin : g_shift
    beat_t sh_q [LAT-1];
    for (genvar i = 0; i < LAT - 1; i++) begin : g_stage
      beat_t sh_d;
      if (i == 0) begin : g_first
        assign sh_d = head;
      end else begin : g_next
        assign sh_d = sh_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q[i] <= '0;
        else        sh_q[i] <= sh_d;
      end
    end
    assign tail = sh_q[LAT-2];
  end

  // R5: a returned word appears a fixed latency after its accepted strobe
  p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tail.vld == $past(acc, LAT));

  // R4: the block marker never stands alone
  p_sob_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tail.sob |-> tail.vld);
endmodule

// File: rtl/blkbuf_two_page.sv
module blkbuf_two_page
  import blkbuf_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int MIN_LOG2 = 3,
  parameter int RD_LAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sob,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  sz_x,
  input  logic [SEL_W-1:0]  sz_y,
  input  logic              rd_req,
  output logic              rdy,
  output logic              rd_valid,
  output logic              rd_sob,
  output logic [WORD_W-1:0] rd_data,
  output logic              ovf_flt,
  output logic              unf_flt
);
  localparam int AW = 2 * (MIN_LOG2 + (1 << SEL_W) - 1) - $clog2(LANES);

  logic [1:0]          full_q, full_d;
  logic                ovf_q, ovf_d, unf_q, unf_d;
  logic                flush;
  logic                mem_we, ovf_evt, blk_done, wr_page;
  logic [AW:0]         mem_waddr, mem_raddr;
  logic [1:0][AW-1:0]  plen_m1;
  logic                acc, unf_evt, rd_last, rd_page, first;
  word_t               mem_q;
  beat_t               tail;

  assign flush = ovf_evt || unf_evt;

  blkbuf_wr_ctrl #(.SEL_W(SEL_W), .MIN_LOG2(MIN_LOG2), .LANES(LANES), .AW(AW)) i_wr (
    .clk, .rst_n, .flush, .wr_en, .wr_sob, .sz_x, .sz_y,
    .page_full(full_q), .rd_last, .rd_page,
    .mem_we, .mem_waddr, .ovf_evt, .blk_done, .wr_page, .plen_m1
  );

  blkbuf_rd_ctrl #(.AW(AW)) i_rd (
    .clk, .rst_n, .flush, .rd_req, .page_full(full_q), .plen_m1,
    .rdy, .acc, .unf_evt, .rd_last, .rd_page, .first, .mem_raddr
  );

  blkbuf_store #(.W(WORD_W), .AW(AW)) i_store (
    .clk, .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .re(acc), .raddr(mem_raddr), .rdata(mem_q)
  );

  blkbuf_rd_pipe #(.LAT(RD_LAT)) i_pipe (
    .clk, .rst_n, .acc, .first, .mem_q, .tail
  );

  always_comb begin
    full_d = full_q;
    ovf_d  = ovf_q;
    unf_d  = unf_q;
    if (flush) begin
      full_d = '0;
      ovf_d  = ovf_q || ovf_evt;
      unf_d  = unf_q || unf_evt;
    end else begin
      if (rd_last)  full_d[rd_page] = 1'b0;
      if (blk_done) full_d[wr_page] = 1'b1;
      if (rd_last) begin
        ovf_d = 1'b0;
        unf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      full_q <= full_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

  assign rd_valid = tail.vld;
  assign rd_sob   = tail.sob;
  assign rd_data  = tail.data;
  assign ovf_flt  = ovf_q;
  assign unf_flt  = unf_q;

  // R3: availability only drops through a read or a fault
  p_rdy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !rd_req && !flush) |=> rdy);

  // R6: a strobe on an empty buffer is recorded
  p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> unf_flt);

  // R8: a fault leaves nothing to read
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rdy);

  // R8: faults persist until a block has drained
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flt && !rd_last) |=> ovf_flt);
endmodule

// File: tb/test_blkbuf_two_page.sv
module test_blkbuf_two_page;
  import blkbuf_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sob = 1'b0, rd_req = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  sz_x = '0, sz_y = '0;
  logic        rdy, rd_valid, rd_sob, ovf_flt, unf_flt;
  logic [15:0] rd_data;

  always #10 clk = ~clk;

  blkbuf_two_page i_blkbuf_two_page (
    .clk, .rst_n, .wr_en, .wr_sob, .wr_data, .sz_x, .sz_y, .rd_req,
    .rdy, .rd_valid, .rd_sob, .rd_data, .ovf_flt, .unf_flt
  );

  int n_chk = 0, n_err = 0;
  bit fin = 0;

  // behavioural reference
  logic [15:0] done_q[$];
  int          len_q[$];
  logic [15:0] cur_q[$];
  bit          m_act, m_ovf, m_unf;
  int          m_len, m_ridx;
  bit          pv[4], ps[4];
  logic [15:0] pd[4];
  bit          t_acc, t_unf, t_last, t_ovf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q.delete(); len_q.delete(); cur_q.delete();
      m_act = 0; m_ovf = 0; m_unf = 0; m_len = 0; m_ridx = 0;
      for (int k = 0; k < 4; k++) begin pv[k] = 0; ps[k] = 0; pd[k] = '0; end
    end else begin
      t_acc  = rd_req && (len_q.size() > 0);
      t_unf  = rd_req && (len_q.size() == 0);
      t_last = t_acc && (m_ridx == len_q[0] - 1);
      t_ovf  = wr_en && wr_sob && (len_q.size() == 2) && !t_last;
      for (int k = 3; k > 0; k--) begin pv[k] = pv[k-1]; ps[k] = ps[k-1]; pd[k] = pd[k-1]; end
      pv[0] = t_acc;
      ps[0] = t_acc && (m_ridx == 0);
      if (t_acc) pd[0] = done_q[0];
      if (t_ovf || t_unf) begin
        m_ovf = m_ovf || t_ovf;
        m_unf = m_unf || t_unf;
        done_q.delete(); len_q.delete(); cur_q.delete();
        m_act = 0; m_ridx = 0;
      end else begin
        if (t_acc) begin
          void'(done_q.pop_front());
          m_ridx++;
          if (t_last) begin
            void'(len_q.pop_front());
            m_ridx = 0; m_ovf = 0; m_unf = 0;
          end
        end
        if (wr_en && wr_sob) begin
          cur_q.delete();
          cur_q.push_back(wr_data);
          m_act = 1;
          m_len = 16 << (int'(sz_x) + int'(sz_y));
        end else if (wr_en && m_act) begin
          cur_q.push_back(wr_data);
        end
        if (m_act && cur_q.size() == m_len) begin
          foreach (cur_q[j]) done_q.push_back(cur_q[j]);
          len_q.push_back(m_len);
          cur_q.delete();
          m_act = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(rdy == (len_q.size() > 0), "R3 rdy", int'(rdy), int'(len_q.size() > 0));
    chk(rd_valid == pv[3], "R5 rd_valid", int'(rd_valid), int'(pv[3]));
    if (pv[3]) begin
      chk(rd_data == pd[3], "R1 rd_data", int'(rd_data), int'(pd[3]));
      chk(rd_sob == ps[3], "R4 rd_sob", int'(rd_sob), int'(ps[3]));
    end
    chk(ovf_flt == m_ovf, "R7 ovf_flt", int'(ovf_flt), int'(m_ovf));
    chk(unf_flt == m_unf, "R6 unf_flt", int'(unf_flt), int'(m_unf));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic put(input int sx, input int sy, input int seed, input int n, input bit chg);
    for (int i = 0; i < n; i++) begin
      wr_en   = 1'b1;
      wr_sob  = (i == 0);
      wr_data = 16'(seed * 4099 + i * 37 + 1);
      if (i == 0) begin sz_x = 2'(sx); sz_y = 2'(sy); end
      else if (chg) sz_x = 2'(3 - sx);
      cyc();
    end
    wr_en = 1'b0; wr_sob = 1'b0;
  endtask

  task automatic get(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      rd_req = 1'b1; cyc(); rd_req = 1'b0;
      idle(gap);
    end
  endtask

  initial begin
    #1;
    chk(rdy == 0 && rd_valid == 0, "R11 reset outputs", int'({rdy, rd_valid}), 0);
    chk(ovf_flt == 0 && unf_flt == 0, "R11 reset faults", int'({ovf_flt, unf_flt}), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk(rdy == 0, "R11 empty after reset", int'(rdy), 0);

    // basic block, spaced reads
    put(0, 0, 1, 16, 0);
    chk(rdy == 1, "R3 block ready", int'(rdy), 1);
    get(16, 1); idle(5);
    chk(rdy == 0, "R3 drained", int'(rdy), 0);

    // R12 stray words
    wr_en = 1'b1; wr_data = 16'h5a5a; idle(5); wr_en = 1'b0;
    chk(rdy == 0, "R12 stray words ignored", int'(rdy), 0);

    // R9 size sampled on start word only
    put(1, 0, 2, 16, 1);
    chk(rdy == 0, "R9 block longer than 16", int'(rdy), 0);
    wr_en = 1'b1;
    for (int i = 16; i < 32; i++) begin wr_data = 16'(2 * 4099 + i * 37 + 1); cyc(); end
    wr_en = 1'b0;
    chk(rdy == 1, "R9 32-word block complete", int'(rdy), 1);
    get(32, 0); idle(5);
    chk(rdy == 0, "R9 block drained", int'(rdy), 0);

    // R10 restart mid-block
    put(0, 0, 3, 10, 0);
    put(0, 0, 4, 16, 0);
    chk(rdy == 1, "R10 restarted block complete", int'(rdy), 1);
    get(15, 0);
    chk(rdy == 1, "R10 one word left", int'(rdy), 1);
    get(1, 0); idle(5);
    chk(rdy == 0, "R10 no leftover block", int'(rdy), 0);

    // R2 two blocks, R7 third start overflows
    put(0, 0, 5, 16, 0);
    put(0, 0, 6, 16, 0);
    chk(ovf_flt == 0 && rdy == 1, "R2 two blocks held", int'({ovf_flt, rdy}), 1);
    put(0, 0, 7, 16, 0);
    chk(ovf_flt == 1, "R7 overflow raised", int'(ovf_flt), 1);
    chk(rdy == 0, "R8 overflow empties buffer", int'(rdy), 0);
    put(0, 0, 8, 16, 0);
    chk(ovf_flt == 1, "R8 fault held before drain", int'(ovf_flt), 1);
    get(16, 0); idle(4);
    chk(ovf_flt == 0 && unf_flt == 0, "R8 faults cleared", int'({ovf_flt, unf_flt}), 0);

    // R7 start in the same cycle the older block finishes
    put(0, 0, 9, 16, 0);
    put(0, 0, 10, 16, 0);
    get(15, 0);
    rd_req = 1'b1; wr_en = 1'b1; wr_sob = 1'b1; sz_x = 0; sz_y = 0;
    wr_data = 16'(11 * 4099 + 1);
    cyc();
    rd_req = 1'b0; wr_sob = 1'b0;
    for (int i = 1; i < 16; i++) begin wr_data = 16'(11 * 4099 + i * 37 + 1); cyc(); end
    wr_en = 1'b0;
    chk(ovf_flt == 0, "R7 same-cycle free accepted", int'(ovf_flt), 0);
    get(32, 0); idle(5);
    chk(rdy == 0, "R4 both blocks drained", int'(rdy), 0);

    // R6 underflow, R8 partial block dropped
    put(0, 0, 12, 5, 0);
    rd_req = 1'b1; cyc(); rd_req = 1'b0;
    chk(unf_flt == 1, "R6 underflow raised", int'(unf_flt), 1);
    wr_en = 1'b1;
    for (int i = 5; i < 16; i++) begin wr_data = 16'(i); cyc(); end
    wr_en = 1'b0;
    chk(rdy == 0, "R8 partial block dropped", int'(rdy), 0);
    put(0, 0, 13, 16, 0);
    get(16, 0); idle(4);
    chk(unf_flt == 0, "R8 underflow cleared", int'(unf_flt), 0);

    // concurrent write and back-to-back read
    put(0, 0, 14, 16, 0);
    for (int i = 0; i < 16; i++) begin
      rd_req = 1'b1; wr_en = 1'b1; wr_sob = (i == 0);
      wr_data = 16'(15 * 4099 + i * 37 + 1);
      cyc();
    end
    rd_req = 1'b0; wr_en = 1'b0; wr_sob = 1'b0;
    chk(rdy == 1, "R2 second page ready", int'(rdy), 1);
    get(16, 0); idle(5);

    // largest block
    put(3, 3, 16, 1024, 0);
    chk(rdy == 1, "R9 1024-word block ready", int'(rdy), 1);
    get(1024, 0); idle(6);
    chk(rdy == 0, "R9 1024-word block drained", int'(rdy), 0);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule